// File: doc/BRIEF.md
# Tagged Free-List Frame Allocator

This engine hands out and takes back fixed-size memory frames. Each size class owns a singly linked free list. The head of every list lives in an allocation vector: a run of words that starts at a fixed base address and is indexed by the frame size index. The two low bits of a head word are a tag. The tag says whether the word points at a free frame, whether the list is empty, or whether the request must be retried in another size class. The engine reaches memory only through one single-port word interface whose read data arrives a fixed number of cycles after the read is issued.

An allocate request carries a size index. The engine answers with a frame address, or it reports a failure together with a parameter. A free request carries a frame address. The engine reads the frame's size index from the word just below the frame. It then pushes the frame onto the head of that class's list. Only one request is handled at a time, and `done` marks its completion.

Top module: `frame_alloc_engine`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `busy`, `done`, `mem_rd` and `mem_wr` are low, and `frame_addr`, `fail` and `hop_fail` read zero.
- R2: An allocation reads the head word at address `VEC_BASE + fsi`. Bits [1:0] of that word are its tag.
- R3: Tag 2'b00 means the head word is a free frame address. The engine returns it on `frame_addr` with `fail` low, and writes the word stored at that frame (its link) into the head word.
- R4: Tag 2'b01 means the list is empty. The engine completes with `fail` high, `hop_fail` low and `fail_param` equal to twice the size index originally requested, and memory is left unchanged.
- R5: Tag 2'b10 redirects the request. The new size index is the low `SIW` bits of the head word shifted right by two, and the lookup starts again with that index.
- R6: Tag 2'b11 behaves exactly as tag 2'b10.
- R7: An allocation may take at most `MAX_HOPS` redirections. If another redirect tag is met after that, the request completes with `fail` and `hop_fail` high and `fail_param` equal to twice the original size index, and memory is left unchanged.
- R8: A free takes the size index from the low `SIW` bits of the word at the frame address minus one.
- R9: A free writes the class's current head into word 0 of the released frame and then writes the frame address into the head word. The next allocation of that class therefore returns the frame just freed.
- R10: When a free completes, `fail` is low and `frame_addr` holds the released address. It keeps that value until another request is accepted.
- R11: A request is accepted only while `busy` is low. Requests that arrive while busy have no effect. If `alloc_req` and `free_req` are both high in an idle cycle, the allocation is taken.
- R12: `done` is high for exactly one cycle per request. Read data is taken exactly `RD_LAT` cycles after its read. No read is issued in two consecutive cycles, and a read and a write never share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Start an allocation (sampled while idle) |
| alloc_fsi | input | SIW | Size index to allocate |
| free_req | input | 1 | Start a release (sampled while idle) |
| free_addr | input | AW | Address of the frame to release |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Last allocation failed |
| hop_fail | output | 1 | The failure came from the redirection limit |
| fail_param | output | AW | Twice the originally requested size index |
| frame_addr | output | AW | Allocated or released frame address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | AW | Memory write data |
| mem_rdata | input | AW | Memory read data, valid RD_LAT cycles after mem_rd |

## Verification
The bench targets the following corner cases:
- A chain of exactly `MAX_HOPS` redirections must still succeed, while one more redirection must fail with `hop_fail`. An off-by-one limit flips one of these two outcomes.
- A two-class redirect cycle must end in failure rather than hang.
- A tag 2'b11 entry and a redirect word with high bits set both exercise the decode. Wrong decoding sends the lookup to the wrong class.
- A free followed by an allocation exposes a swapped link/head write order, because the frame comes back linked to itself or the list is lost.
- The memory model returns a garbage word on every cycle except the one exactly `RD_LAT` after a read. Sampling early or late therefore corrupts the results.
- Requests raised while busy, and simultaneous allocate and free, are checked against the memory image. A design that accepted them would change the lists.

// File: rtl/fa_pkg.sv
package fa_pkg;

    // What a list-head word asks the engine to do
    typedef enum logic [1:0] {
        K_POP   = 2'd0,
        K_EMPTY = 2'd1,
        K_REDIR = 2'd2
    } head_kind_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_A_RDHEAD,
        S_A_WTHEAD,
        S_A_RDLINK,
        S_A_WTLINK,
        S_A_WRHEAD,
        S_F_RDSZ,
        S_F_WTSZ,
        S_F_RDHEAD,
        S_F_WTHEAD,
        S_F_WRFRM,
        S_F_WRHEAD,
        S_FINISH
    } eng_state_e;

    typedef struct packed {
        logic fail;
        logic hop_fail;
    } outcome_t;

    function automatic head_kind_e classify_tag(input logic [1:0] tag);
        case (tag)
            2'b00:   return K_POP;
            2'b01:   return K_EMPTY;
            default: return K_REDIR;
        endcase
    endfunction

endpackage

// File: rtl/fa_tag_decode.sv
module fa_tag_decode
    import fa_pkg::*;
#(
    parameter int SIW = 4
) (
    input  logic [SIW+1:0]   head_word,
    output head_kind_e       kind,
    output logic [SIW-1:0]   redirect_fsi
);
    always_comb begin
        kind         = classify_tag(head_word[1:0]);
        redirect_fsi = head_word[SIW+1:2];
    end
endmodule

// File: rtl/fa_rd_timer.sv
module fa_rd_timer #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic ready
);
    localparam int CW = $clog2(RD_LAT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= CW'(RD_LAT - 1);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign ready = (cnt_q == '0);

    // A new read may only start once the previous one has delivered its data
    assert_no_overlap_R12: assert property (@(posedge clk) disable iff (rst)
        load |-> ready);
endmodule

// File: rtl/fa_hop_limit.sv
module fa_hop_limit #(
    parameter int MAX_HOPS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic at_limit
);
    localparam int HW = (MAX_HOPS < 1) ? 1 : $clog2(MAX_HOPS + 1);

    logic [HW-1:0] hops_q;

    always_ff @(posedge clk) begin
        if (rst)         hops_q <= '0;
        else if (clear)  hops_q <= '0;
        else if (step)   hops_q <= hops_q + 1'b1;
    end

    assign at_limit = (hops_q == HW'(MAX_HOPS));

    assert_hop_cap_R7: assert property (@(posedge clk) disable iff (rst)
        step |-> !at_limit);

    assert_hop_bound_R7: assert property (@(posedge clk) disable iff (rst)
        hops_q <= HW'(MAX_HOPS));
endmodule

// File: rtl/frame_alloc_engine.sv
module frame_alloc_engine
    import fa_pkg::*;
#(
    parameter int AW       = 16,
    parameter int SIW      = 4,
    parameter int VEC_BASE = 64,
    parameter int RD_LAT   = 2,
    parameter int MAX_HOPS = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           alloc_req,
    input  logic [SIW-1:0] alloc_fsi,
    input  logic           free_req,
    input  logic [AW-1:0]  free_addr,
    output logic           busy,
    output logic           done,
    output logic           fail,
    output logic           hop_fail,
    output logic [AW-1:0]  fail_param,
    output logic [AW-1:0]  frame_addr,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic [AW-1:0]  mem_addr,
    output logic [AW-1:0]  mem_wdata,
    input  logic [AW-1:0]  mem_rdata
);
    localparam logic [AW-1:0] BASE_W = AW'(VEC_BASE);
    localparam int            PADW   = AW - SIW - 1;

    eng_state_e     state_q;
    logic [SIW-1:0] cur_fsi_q, orig_fsi_q;
    logic [AW-1:0]  entry_addr_q, frame_q, link_q;
    outcome_t       res_q;

    logic [AW-1:0]  head_addr;
    head_kind_e     kind;
    logic [SIW-1:0] redirect_fsi;
    logic           rd_ready, at_limit, hop_clear, hop_step;

    assign head_addr = BASE_W + AW'(cur_fsi_q);

    fa_tag_decode #(.SIW(SIW)) u_dec (
        .head_word    (mem_rdata[SIW+1:0]),
        .kind         (kind),
        .redirect_fsi (redirect_fsi)
    );

    fa_rd_timer #(.RD_LAT(RD_LAT)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .load  (mem_rd),
        .ready (rd_ready)
    );

    assign hop_clear = (state_q == S_IDLE) && alloc_req;
    assign hop_step  = (state_q == S_A_WTHEAD) && rd_ready
                       && (kind == K_REDIR) && !at_limit;

    fa_hop_limit #(.MAX_HOPS(MAX_HOPS)) u_hops (
        .clk      (clk),
        .rst      (rst),
        .clear    (hop_clear),
        .step     (hop_step),
        .at_limit (at_limit)
    );

    // Memory port drive, decoded from the sequencer state
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            S_A_RDHEAD, S_F_RDHEAD: begin
                mem_rd   = 1'b1;
                mem_addr = head_addr;
            end
            S_A_RDLINK: begin
                mem_rd   = 1'b1;
                mem_addr = frame_q;
            end
            S_A_WRHEAD: begin
                mem_wr    = 1'b1;
                mem_addr  = entry_addr_q;
                mem_wdata = link_q;
            end
            S_F_RDSZ: begin
                mem_rd   = 1'b1;
                mem_addr = frame_q - 1'b1;
            end
            S_F_WRFRM: begin
                mem_wr    = 1'b1;
                mem_addr  = frame_q;
                mem_wdata = link_q;
            end
            S_F_WRHEAD: begin
                mem_wr    = 1'b1;
                mem_addr  = entry_addr_q;
                mem_wdata = frame_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            cur_fsi_q    <= '0;
            orig_fsi_q   <= '0;
            entry_addr_q <= '0;
            frame_q      <= '0;
            link_q       <= '0;
            res_q        <= '{fail: 1'b0, hop_fail: 1'b0};
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (alloc_req) begin
                        cur_fsi_q  <= alloc_fsi;
                        orig_fsi_q <= alloc_fsi;
                        state_q    <= S_A_RDHEAD;
                    end else if (free_req) begin
                        frame_q <= free_addr;
                        state_q <= S_F_RDSZ;
                    end
                end
                S_A_RDHEAD: begin
                    entry_addr_q <= head_addr;
                    state_q      <= S_A_WTHEAD;
                end
                S_A_WTHEAD: begin
                    if (rd_ready) begin
                        case (kind)
                            K_POP: begin
                                frame_q <= mem_rdata;
                                res_q   <= '{fail: 1'b0, hop_fail: 1'b0};
                                state_q <= S_A_RDLINK;
                            end
                            K_EMPTY: begin
                                res_q   <= '{fail: 1'b1, hop_fail: 1'b0};
                                state_q <= S_FINISH;
                            end
                            default: begin
                                if (at_limit) begin
                                    res_q   <= '{fail: 1'b1, hop_fail: 1'b1};
                                    state_q <= S_FINISH;
                                end else begin
                                    cur_fsi_q <= redirect_fsi;
                                    state_q   <= S_A_RDHEAD;
                                end
                            end
                        endcase
                    end
                end
                S_A_RDLINK: state_q <= S_A_WTLINK;
                S_A_WTLINK: begin
                    if (rd_ready) begin
                        link_q  <= mem_rdata;
                        state_q <= S_A_WRHEAD;
                    end
                end
                S_A_WRHEAD: state_q <= S_FINISH;
                S_F_RDSZ:   state_q <= S_F_WTSZ;
                S_F_WTSZ: begin
                    if (rd_ready) begin
                        cur_fsi_q <= mem_rdata[SIW-1:0];
                        state_q   <= S_F_RDHEAD;
                    end
                end
                S_F_RDHEAD: begin
                    entry_addr_q <= head_addr;
                    state_q      <= S_F_WTHEAD;
                end
                S_F_WTHEAD: begin
                    if (rd_ready) begin
                        link_q  <= mem_rdata;
                        state_q <= S_F_WRFRM;
                    end
                end
                S_F_WRFRM: state_q <= S_F_WRHEAD;
                S_F_WRHEAD: begin
                    res_q   <= '{fail: 1'b0, hop_fail: 1'b0};
                    state_q <= S_FINISH;
                end
                S_FINISH:  state_q <= S_IDLE;
                default:   state_q <= S_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != S_IDLE);
    assign done       = (state_q == S_FINISH);
    assign fail       = res_q.fail;
    assign hop_fail   = res_q.hop_fail;
    assign frame_addr = frame_q;
    assign fail_param = {{PADW{1'b0}}, orig_fsi_q, 1'b0};

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !mem_rd && !mem_wr));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_read_spacing_R12: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    assert_single_port_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));

    assert_start_on_req_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(alloc_req || free_req));
endmodule

// File: tb/sim_frame_alloc_engine.sv
module sim_frame_alloc_engine;
    localparam int AW   = 16;
    localparam int SIW  = 4;
    localparam int VB   = 64;
    localparam int LAT  = 2;
    localparam int HOPS = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           alloc_req = 1'b0;
    logic [SIW-1:0] alloc_fsi = '0;
    logic           free_req = 1'b0;
    logic [AW-1:0]  free_addr = '0;
    logic           busy, done, fail, hop_fail;
    logic [AW-1:0]  fail_param, frame_addr;
    logic           mem_rd, mem_wr;
    logic [AW-1:0]  mem_addr, mem_wdata, mem_rdata;

    logic           tb_we = 1'b0;
    logic [7:0]     tb_wa = '0;
    logic [AW-1:0]  tb_wd = '0;

    logic [AW-1:0]  mem [256];
    logic [AW-1:0]  sh  [256];
    logic [AW-1:0]  pipe_d [LAT];
    logic           pipe_v [LAT];

    int checks = 0;
    int errors = 0;
    int issued = 0;
    int done_cnt = 0;
    logic prev_done = 1'b0;

    typedef struct {
        logic [AW-1:0] frame;
        logic          fl;
        logic          hp;
        logic [AW-1:0] prm;
        string         rq;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    frame_alloc_engine #(.AW(AW), .SIW(SIW), .VEC_BASE(VB), .RD_LAT(LAT), .MAX_HOPS(HOPS)) u0 (
        .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_fsi(alloc_fsi),
        .free_req(free_req), .free_addr(free_addr), .busy(busy), .done(done),
        .fail(fail), .hop_fail(hop_fail), .fail_param(fail_param),
        .frame_addr(frame_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: data is visible only in the exact cycle RD_LAT after the read
    always @(posedge clk) begin
        if (tb_we)       mem[tb_wa] <= tb_wd;
        else if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        pipe_d[0] <= mem[mem_addr[7:0]];
        pipe_v[0] <= mem_rd;
        for (int i = 1; i < LAT; i++) begin
            pipe_d[i] <= pipe_d[i-1];
            pipe_v[i] <= pipe_v[i-1];
        end
    end
    assign mem_rdata = pipe_v[LAT-1] ? pipe_d[LAT-1] : 16'hBEEF;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard whenever the design signals completion
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (prev_done) check(1'b0, "R12", "done wider than one cycle", 16'd1, 16'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected done", 16'd1, 16'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(fail == e.fl && hop_fail == e.hp, e.rq, "fail/hop_fail",
                          {14'd0, fail, hop_fail}, {14'd0, e.fl, e.hp});
                    if (!e.fl) check(frame_addr == e.frame, e.rq, "frame_addr", frame_addr, e.frame);
                    else       check(fail_param == e.prm, e.rq, "fail_param", fail_param, e.prm);
                end
                done_cnt++;
            end
            prev_done <= done;
        end
    end

    task automatic poke(input int a, input logic [AW-1:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_wa = 8'(a); tb_wd = d;
        sh[a] = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    function automatic exp_t model_alloc(input int fsi, input string rq);
        exp_t e;
        int cur = fsi;
        int hops = 0;
        e.frame = '0; e.fl = 1'b0; e.hp = 1'b0; e.prm = AW'(2 * fsi); e.rq = rq;
        forever begin
            logic [AW-1:0] w;
            w = sh[VB + cur];
            if (w[1:0] == 2'b00) begin
                e.frame = w;
                sh[VB + cur] = sh[w[7:0]];
                return e;
            end else if (w[1:0] == 2'b01) begin
                e.fl = 1'b1;
                return e;
            end else if (hops == HOPS) begin
                e.fl = 1'b1; e.hp = 1'b1;
                return e;
            end else begin
                cur = int'((w >> 2) & 16'(2**SIW - 1));
                hops++;
            end
        end
    endfunction

    function automatic exp_t model_free(input logic [AW-1:0] a, input string rq);
        exp_t e;
        int s;
        s = int'(sh[a[7:0] - 8'd1] & 16'(2**SIW - 1));
        sh[a[7:0]] = sh[VB + s];
        sh[VB + s] = a;
        e.frame = a; e.fl = 1'b0; e.hp = 1'b0; e.prm = '0; e.rq = rq;
        return e;
    endfunction

    task automatic wait_done();
        while (done_cnt != issued) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_alloc(input int fsi, input string rq);
        exp_q.push_back(model_alloc(fsi, rq));
        issued++;
        @(negedge clk);
        alloc_fsi = SIW'(fsi); alloc_req = 1'b1;
        @(negedge clk);
        alloc_req = 1'b0;
        wait_done();
    endtask

    task automatic run_free(input logic [AW-1:0] a, input string rq);
        exp_q.push_back(model_free(a, rq));
        issued++;
        @(negedge clk);
        free_addr = a; free_req = 1'b1;
        @(negedge clk);
        free_req = 1'b0;
        wait_done();
    endtask

    task automatic check_mem(input string rq);
        int bad = -1;
        for (int i = 0; i < 256; i++)
            if (bad < 0 && mem[i] !== sh[i]) bad = i;
        if (bad >= 0) check(1'b0, rq, $sformatf("memory word %0d", bad), mem[bad], sh[bad]);
        else          check(1'b1, rq, "memory image", '0, '0);
    endtask

    initial begin
        for (int i = 0; i < LAT; i++) begin pipe_v[i] = 1'b0; pipe_d[i] = '0; end
        for (int i = 0; i < 256; i++) poke(i, 16'h0001);
        // class 1: 0x80 -> 0x90 -> empty
        poke(VB + 1, 16'h0080); poke('h80, 16'h0090); poke('h90, 16'h0001);
        poke('h7F, 16'h0001);   poke('h8F, 16'h0001);
        poke(VB + 3, 16'h0006);               // tag 10 -> class 1
        poke(VB + 4, 16'h000F);               // tag 11 -> class 3
        poke(VB + 5, 16'h001A);               // -> class 6
        poke(VB + 6, 16'h0016);               // -> class 5 (cycle)
        poke(VB + 7, 16'h0022);               // -> 8
        poke(VB + 8, 16'h0026);               // -> 9
        poke(VB + 9, 16'h002A);               // -> 10
        poke(VB + 10, 16'h00A0); poke('hA0, 16'h0001);
        poke(VB + 11, 16'h001E);              // -> 7, one hop too many
        poke(VB + 13, 16'hFF06);              // high bits dropped -> class 1
        poke('hAF, 16'h0002);                 // size word of frame 0xB0
        @(negedge clk);
        check(!busy && !done && !mem_rd && !mem_wr, "R1", "idle in reset",
              {12'd0, busy, done, mem_rd, mem_wr}, '0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_rd && !mem_wr && !fail && !hop_fail && frame_addr == '0,
              "R1", "idle after reset", frame_addr, '0);

        run_alloc(1, "R3");  check_mem("R3");
        run_alloc(2, "R4");  check_mem("R4");
        run_alloc(3, "R5");  check_mem("R5");
        run_alloc(1, "R2");  check_mem("R2");
        run_free(16'h0080, "R8"); check_mem("R8");
        repeat (5) @(negedge clk);
        check(frame_addr == 16'h0080 && !fail, "R10", "released address held", frame_addr, 16'h0080);
        run_free(16'h0090, "R9"); check_mem("R9");
        run_alloc(4, "R6");  check_mem("R6");
        run_alloc(7, "R7");  check_mem("R7");
        run_alloc(11, "R7"); check_mem("R7");
        run_alloc(5, "R7");  check_mem("R7");
        run_alloc(13, "R5"); check_mem("R5");

        // Requests while busy are ignored
        exp_q.push_back(model_alloc(2, "R11"));
        issued++;
        @(negedge clk); alloc_fsi = 4'd2; alloc_req = 1'b1;
        @(negedge clk); alloc_req = 1'b0; free_addr = 16'h00B0; free_req = 1'b1;
        check(busy, "R11", "busy during request", {15'd0, busy}, 16'd1);
        @(negedge clk);
        @(negedge clk); free_req = 1'b0;
        wait_done();
        repeat (4) @(negedge clk);
        check(done_cnt == issued, "R11", "single completion", AW'(done_cnt), AW'(issued));
        check_mem("R11");

        // Simultaneous requests: allocation wins
        exp_q.push_back(model_alloc(2, "R11"));
        issued++;
        @(negedge clk); alloc_fsi = 4'd2; alloc_req = 1'b1; free_addr = 16'h00B0; free_req = 1'b1;
        @(negedge clk); alloc_req = 1'b0; free_req = 1'b0;
        wait_done();
        check_mem("R11");

        run_free(16'h00B0, "R10"); check_mem("R9");
        run_alloc(2, "R9");        check_mem("R9");
        check(exp_q.size() == 0, "R12", "all results seen", AW'(exp_q.size()), '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R12 watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule